// File: doc/BRIEF.md
# Serial Adapter Status and Interrupt Controller

This block keeps the status byte and the interrupt request of an asynchronous serial adapter on a processor bus. It takes the bus register-select and read/write strobes, the active-low modem inputs for carrier detect, data-set-ready and clear-to-send, and single-cycle event pulses from the receiver and transmitter. From these it keeps the receive, transmit and error flags, combines them with the command-register enables into one active-low interrupt request, and drives the data-terminal-ready and request-to-send modem outputs.

Software services an interrupt by reading the status byte. The read clears the interrupt flag. A bus write to the status address is a software reset. It turns off the adapter and its interrupt enables but leaves most flags in place. It drops a pending interrupt that a modem line raised and keeps a pending interrupt that a data event raised. The serial shifters, the baud generator and the data registers sit outside the block. Their bus strobes still reach it, because a data read or write changes the flags.

Top module: `sacia_status_irq`

## Requirements
- R1: The status byte has this layout: bit 7 interrupt flag, bit 6 synchronised DSR level, bit 5 synchronised DCD level, bit 4 transmit-empty, bit 3 receive-full, bit 2 overrun, bit 1 framing error, bit 0 parity error. The interrupt flag reads 1 exactly when `irq_n` is low.
- R2: After hardware reset the status byte reads 0x70 while the modem inputs are high. `irq_n`, `dtr_n` and `rts_n` are high and `tx_run` is low.
- R3: `rx_done` sets receive-full and loads the parity and framing bits from `rx_par_err` and `rx_frm_err`. A data read (`bus_rd`, `rs`=00) clears receive-full, parity, framing and overrun. A new character in the same cycle as the read takes priority.
- R4: `rx_done` while receive-full is set and no data read is in progress sets overrun. The parity and framing bits keep the values of the earlier character.
- R5: A data write (`bus_wr`, `rs`=00) clears transmit-empty. `tx_empty_evt` sets it, and the set wins when both happen in the same cycle.
- R6: With the adapter enabled, `rx_done` with receive interrupts on, or `tx_empty_evt` with transmit interrupts on, drives `irq_n` low one cycle later.
- R7: A status read (`bus_rd`, `rs`=10) clears the interrupt flag one cycle later, unless a new enabled event arrives in the same cycle.
- R8: A change on `dcd_n` or `dsr_n` shows in its status bit two cycles later. With modem interrupts on and the adapter enabled, it drives `irq_n` low three cycles later.
- R9: A rise of `cts_n` (deassertion) drives `irq_n` low three cycles later when the adapter and transmit interrupts are enabled. A fall of `cts_n` raises nothing.
- R10: A software reset (`bus_wr`, `rs`=10) clears the enable, receive, transmit and modem interrupt enables and the overrun flag. `dtr_n` is high and `tx_run` is low from the next cycle. The echo and RTS bits keep their values.
- R11: On software reset, a pending interrupt raised by a modem line is released and one raised by a data event stays. Afterwards the DCD and DSR bits follow their pins but raise no interrupt.
- R12: While the enable bit is 0, no event of any kind raises the interrupt flag, and `tx_run` is low.
- R13: A command write (`bus_wr`, `rs`=11) loads `wdata` as follows: bit 0 enable (drives `dtr_n` low and `tx_run` high), bit 1 receive interrupt enable, bit 2 transmit interrupt enable, bit 3 echo, bit 4 modem interrupt enable, bit 5 RTS request. `rts_n` is low when echo or the RTS request is set. The new values take effect one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| bus_rd | input | 1 | Bus read strobe, one cycle |
| bus_wr | input | 1 | Bus write strobe, one cycle |
| rs | input | 2 | Register select: 00 data, 10 status or software reset, 11 command |
| wdata | input | 6 | Low bits of the bus write data, used for command writes |
| rx_done | input | 1 | Receiver finished a character (pulse) |
| rx_par_err | input | 1 | Parity error of that character |
| rx_frm_err | input | 1 | Framing error of that character |
| tx_empty_evt | input | 1 | Transmitter took the data register (pulse) |
| dcd_n | input | 1 | Carrier detect, active low, asynchronous |
| dsr_n | input | 1 | Data set ready, active low, asynchronous |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| status | output | 8 | Status byte |
| irq_n | output | 1 | Interrupt request, active low |
| dtr_n | output | 1 | Data terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| tx_run | output | 1 | Transmitter enable |

## Verification
Bus strobes and receiver or transmitter pulses change the flags, the command outputs and the interrupt one cycle after the edge that samples them. A modem pin change reaches its status bit two cycles later and the interrupt three cycles later, one cycle for each synchroniser and history register. The bench drives every input on the falling edge. A cycle model steps with each rising edge, and the bench compares all outputs on the next falling edge. The directed modem checks count the two- and three-cycle delays explicitly, so an extra or a missing register stage is caught.

// File: rtl/sacia_pkg.sv
package sacia_pkg;

    localparam int STAT_W = 8;
    localparam int CMD_W  = 6;

    localparam logic [1:0] RS_DATA = 2'b00;
    localparam logic [1:0] RS_STAT = 2'b10;
    localparam logic [1:0] RS_CMD  = 2'b11;

    // command write bit positions
    localparam int CB_EN   = 0;
    localparam int CB_RXIE = 1;
    localparam int CB_TXIE = 2;
    localparam int CB_ECHO = 3;
    localparam int CB_MDIE = 4;
    localparam int CB_RTS  = 5;

    // modem line order inside the synchroniser vectors
    localparam int ML_DCD = 0;
    localparam int ML_DSR = 1;
    localparam int ML_CTS = 2;
    localparam int MODEM_LINES = 3;

    typedef struct packed {
        logic rts_on;
        logic modem_ie;
        logic echo;
        logic tx_ie;
        logic rx_ie;
        logic en;
    } cmd_t;

    typedef struct packed {
        logic tdre;
        logic rdrf;
        logic ovr;
        logic frm;
        logic par;
    } dflag_t;

    typedef struct packed {
        logic from_data;
        logic from_modem;
    } irq_src_t;

endpackage

// File: rtl/sacia_modem_sync.sv
module sacia_modem_sync #(
    parameter int LINES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pin_n,
    output logic [LINES-1:0] level_n,
    output logic [LINES-1:0] prev_n
);
    localparam int DEPTH = STAGES + 1;

    typedef logic [DEPTH-1:0][LINES-1:0] pipe_t;
    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = pin_n;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign level_n = pipe_q[STAGES-1];
    assign prev_n  = pipe_q[STAGES];

endmodule

// File: rtl/sacia_cmd_reg.sv
module sacia_cmd_reg
    import sacia_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic             soft_rst,
    input  logic [CMD_W-1:0] wdata,
    output cmd_t             cmd
);
    cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d = cmd_q;
        if (soft_rst) begin
            cmd_d.en       = 1'b0;
            cmd_d.rx_ie    = 1'b0;
            cmd_d.tx_ie    = 1'b0;
            cmd_d.modem_ie = 1'b0;
        end else if (cmd_wr) begin
            cmd_d.en       = wdata[CB_EN];
            cmd_d.rx_ie    = wdata[CB_RXIE];
            cmd_d.tx_ie    = wdata[CB_TXIE];
            cmd_d.echo     = wdata[CB_ECHO];
            cmd_d.modem_ie = wdata[CB_MDIE];
            cmd_d.rts_on   = wdata[CB_RTS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    assign cmd = cmd_q;

endmodule

// File: rtl/sacia_data_flags.sv
module sacia_data_flags
    import sacia_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   data_rd,
    input  logic   data_wr,
    input  logic   soft_rst,
    input  logic   rx_done,
    input  logic   par_err,
    input  logic   frm_err,
    input  logic   tx_empty_evt,
    output dflag_t flags
);
    dflag_t fl_d, fl_q;
    logic   full_stays;

    always_comb begin
        fl_d       = fl_q;
        full_stays = fl_q.rdrf & ~data_rd;

        fl_d.rdrf = rx_done | full_stays;
        fl_d.ovr  = (rx_done & full_stays) | (fl_q.ovr & ~data_rd & ~soft_rst);

        if (rx_done && !full_stays) begin
            fl_d.par = par_err;
            fl_d.frm = frm_err;
        end else if (data_rd) begin
            fl_d.par = 1'b0;
            fl_d.frm = 1'b0;
        end

        fl_d.tdre = tx_empty_evt | (fl_q.tdre & ~data_wr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q      <= '0;
            fl_q.tdre <= 1'b1;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags = fl_q;

endmodule

// File: rtl/sacia_irq_ctrl.sv
module sacia_irq_ctrl
    import sacia_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stat_rd,
    input  logic                   soft_rst,
    input  cmd_t                   cmd,
    input  logic                   rx_done,
    input  logic                   tx_empty_evt,
    input  logic [MODEM_LINES-1:0] level_n,
    input  logic [MODEM_LINES-1:0] prev_n,
    output logic                   irq_flag
);
    irq_src_t src_d, src_q;
    logic     modem_chg, cts_rise, data_ev, modem_ev;

    always_comb begin
        modem_chg = (level_n[ML_DCD] ^ prev_n[ML_DCD]) |
                    (level_n[ML_DSR] ^ prev_n[ML_DSR]);
        cts_rise  = level_n[ML_CTS] & ~prev_n[ML_CTS];

        data_ev  = cmd.en & ((rx_done & cmd.rx_ie) |
                             ((tx_empty_evt | cts_rise) & cmd.tx_ie));
        modem_ev = cmd.en & cmd.modem_ie & modem_chg;

        src_d.from_data  = data_ev | (src_q.from_data & ~stat_rd);
        src_d.from_modem = ~soft_rst & (modem_ev | (src_q.from_modem & ~stat_rd));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_d;
    end

    assign irq_flag = src_q.from_data | src_q.from_modem;

endmodule

// File: rtl/sacia_status_irq.sv
module sacia_status_irq
    import sacia_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        rs,
    input  logic [CMD_W-1:0]  wdata,
    input  logic              rx_done,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    input  logic              tx_empty_evt,
    input  logic              dcd_n,
    input  logic              dsr_n,
    input  logic              cts_n,
    output logic [STAT_W-1:0] status,
    output logic              irq_n,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              tx_run
);
    logic data_rd, data_wr, stat_rd, soft_rst, cmd_wr;
    logic [MODEM_LINES-1:0] pins_n, level_n, prev_n;
    cmd_t   cmd;
    dflag_t flags;
    logic   irq_flag;

    always_comb begin
        data_rd  = bus_rd & (rs == RS_DATA);
        data_wr  = bus_wr & (rs == RS_DATA);
        stat_rd  = bus_rd & (rs == RS_STAT);
        soft_rst = bus_wr & (rs == RS_STAT);
        cmd_wr   = bus_wr & (rs == RS_CMD);
    end

    always_comb begin
        pins_n         = '1;
        pins_n[ML_DCD] = dcd_n;
        pins_n[ML_DSR] = dsr_n;
        pins_n[ML_CTS] = cts_n;
    end

    sacia_modem_sync #(
        .LINES  (MODEM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (pins_n),
        .level_n (level_n),
        .prev_n  (prev_n)
    );

    sacia_cmd_reg u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .soft_rst (soft_rst),
        .wdata    (wdata),
        .cmd      (cmd)
    );

    sacia_data_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .data_rd      (data_rd),
        .data_wr      (data_wr),
        .soft_rst     (soft_rst),
        .rx_done      (rx_done),
        .par_err      (rx_par_err),
        .frm_err      (rx_frm_err),
        .tx_empty_evt (tx_empty_evt),
        .flags        (flags)
    );

    sacia_irq_ctrl u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .stat_rd      (stat_rd),
        .soft_rst     (soft_rst),
        .cmd          (cmd),
        .rx_done      (rx_done),
        .tx_empty_evt (tx_empty_evt),
        .level_n      (level_n),
        .prev_n       (prev_n),
        .irq_flag     (irq_flag)
    );

    always_comb begin
        status = {irq_flag, level_n[ML_DSR], level_n[ML_DCD],
                  flags.tdre, flags.rdrf, flags.ovr, flags.frm, flags.par};
        irq_n  = ~irq_flag;
        dtr_n  = ~cmd.en;
        tx_run = cmd.en;
        rts_n  = ~(cmd.echo | cmd.rts_on);
    end

endmodule

// File: rtl/sacia_status_irq_chk.sv
module sacia_status_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [1:0] rs,
    input logic       en_req,
    input logic       echo_req,
    input logic       rx_done,
    input logic       tx_empty_evt,
    input logic       st_ovr,
    input logic       st_rdrf,
    input logic       st_tdre,
    input logic       irq_n,
    input logic       dtr_n,
    input logic       rts_n,
    input logic       tx_run
);
    AST_SWRST_DTR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && rs == 2'b10) |=> (dtr_n && !tx_run)); // R10

    AST_SWRST_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && rs == 2'b10 && !rx_done) |=> !st_ovr); // R10

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_run && irq_n) |=> irq_n); // R12

    AST_ECHO_RTS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && rs == 2'b11 && echo_req) |=> !rts_n); // R13

    AST_ENABLE_DTR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && rs == 2'b11 && en_req) |=> (!dtr_n && tx_run)); // R13

    AST_RDRF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> st_rdrf); // R3

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && st_rdrf && !(bus_rd && rs == 2'b00)) |=> st_ovr); // R4

    AST_TDRE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty_evt |=> st_tdre); // R5

endmodule

bind sacia_status_irq sacia_status_irq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .rs           (rs),
    .en_req       (wdata[0]),
    .echo_req     (wdata[3]),
    .rx_done      (rx_done),
    .tx_empty_evt (tx_empty_evt),
    .st_ovr       (status[2]),
    .st_rdrf      (status[3]),
    .st_tdre      (status[4]),
    .irq_n        (irq_n),
    .dtr_n        (dtr_n),
    .rts_n        (rts_n),
    .tx_run       (tx_run)
);

// File: tb/sacia_status_irq_tb.sv
`timescale 1ns/1ps
module sacia_status_irq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0] rs = 2'b00;
    logic [5:0] wdata = '0;
    logic       rx_done = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0;
    logic       tx_empty_evt = 1'b0;
    logic       dcd_n = 1'b1, dsr_n = 1'b1, cts_n = 1'b1;
    logic [7:0] status;
    logic       irq_n, dtr_n, rts_n, tx_run;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // bench model state
    logic [2:0] m1, m2, m3;
    logic m_rdrf, m_par, m_frm, m_ovr, m_tdre, m_irqd, m_irqm;
    logic m_en, m_rxie, m_txie, m_echo, m_mdie, m_rts;

    always #5 clk = ~clk;

    sacia_status_irq u_dut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .rs(rs),
        .wdata(wdata), .rx_done(rx_done), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .tx_empty_evt(tx_empty_evt),
        .dcd_n(dcd_n), .dsr_n(dsr_n), .cts_n(cts_n),
        .status(status), .irq_n(irq_n), .dtr_n(dtr_n), .rts_n(rts_n),
        .tx_run(tx_run)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_status();
        return {m_irqd | m_irqm, m2[1], m2[0], m_tdre, m_rdrf, m_ovr, m_frm, m_par};
    endfunction

    task automatic model_reset();
        m1 = '1; m2 = '1; m3 = '1;
        {m_rdrf, m_par, m_frm, m_ovr, m_irqd, m_irqm} = '0;
        m_tdre = 1'b1;
        {m_en, m_rxie, m_txie, m_echo, m_mdie, m_rts} = '0;
    endtask

    task automatic model_step();
        logic swr, cmdw, drd, dwr, srd, mchg, crise, dev, mev, keep;
        logic n_rdrf, n_ovr, n_par, n_frm, n_tdre, n_irqd, n_irqm;
        swr   = bus_wr && rs == 2'b10;
        cmdw  = bus_wr && rs == 2'b11;
        drd   = bus_rd && rs == 2'b00;
        dwr   = bus_wr && rs == 2'b00;
        srd   = bus_rd && rs == 2'b10;
        mchg  = (m2[0] != m3[0]) || (m2[1] != m3[1]);
        crise = m2[2] && !m3[2];
        dev   = m_en && ((rx_done && m_rxie) || ((tx_empty_evt || crise) && m_txie));
        mev   = m_en && m_mdie && mchg;
        keep  = m_rdrf && !drd;
        n_rdrf = rx_done || keep;
        n_ovr  = (rx_done && keep) || (m_ovr && !drd && !swr);
        n_par = m_par; n_frm = m_frm;
        if (rx_done && !keep) begin n_par = rx_par_err; n_frm = rx_frm_err; end
        else if (drd) begin n_par = 1'b0; n_frm = 1'b0; end
        n_tdre = tx_empty_evt || (m_tdre && !dwr);
        n_irqd = dev || (m_irqd && !srd);
        n_irqm = !swr && (mev || (m_irqm && !srd));
        if (swr) begin
            m_en = 1'b0; m_rxie = 1'b0; m_txie = 1'b0; m_mdie = 1'b0;
        end else if (cmdw) begin
            {m_rts, m_mdie, m_echo, m_txie, m_rxie, m_en} = wdata;
        end
        m3 = m2; m2 = m1; m1 = {cts_n, dsr_n, dcd_n};
        m_rdrf = n_rdrf; m_ovr = n_ovr; m_par = n_par; m_frm = n_frm;
        m_tdre = n_tdre; m_irqd = n_irqd; m_irqm = n_irqm;
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk("R1 status", status, m_status());
        chk("R6 irq_n", {7'b0, irq_n}, {7'b0, !(m_irqd || m_irqm)});
        chk("R10 dtr_n", {7'b0, dtr_n}, {7'b0, !m_en});
        chk("R13 rts_n", {7'b0, rts_n}, {7'b0, !(m_echo || m_rts)});
        chk("R12 tx_run", {7'b0, tx_run}, {7'b0, m_en});
    endtask

    task automatic idle();
        bus_rd = 1'b0; bus_wr = 1'b0; rx_done = 1'b0; tx_empty_evt = 1'b0;
        rx_par_err = 1'b0; rx_frm_err = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [5:0] d);
        rs = a; wdata = d; bus_wr = 1'b1; cyc(); idle();
    endtask

    task automatic bus_read(input logic [1:0] a);
        rs = a; bus_rd = 1'b1; cyc(); idle();
    endtask

    task automatic rx_char(input logic p, input logic f);
        rx_done = 1'b1; rx_par_err = p; rx_frm_err = f; cyc(); idle();
    endtask

    task automatic tx_take();
        tx_empty_evt = 1'b1; cyc(); idle();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got 00 expected 01");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state (no edge consumed by the model while idle is exact: nothing changes)
        chk("R2 status", status, 8'h70);
        chk("R2 irq_n", {7'b0, irq_n}, 8'h01);
        chk("R2 dtr_n", {7'b0, dtr_n}, 8'h01);
        chk("R2 rts_n", {7'b0, rts_n}, 8'h01);
        chk("R2 tx_run", {7'b0, tx_run}, 8'h00);

        bus_write(2'b11, 6'h17);
        chk("R13 dtr_n", {7'b0, dtr_n}, 8'h00);
        chk("R13 tx_run", {7'b0, tx_run}, 8'h01);

        rx_char(1'b1, 1'b0);
        chk("R3 status", status, 8'hF9);
        chk("R6 irq_n", {7'b0, irq_n}, 8'h00);
        rx_char(1'b0, 1'b1);
        chk("R4 status", status, 8'hFD);
        bus_read(2'b10);
        chk("R7 status", status, 8'h7D);
        bus_read(2'b00);
        chk("R3 clear", status, 8'h70);

        bus_write(2'b00, 6'h2A);
        chk("R5 clear", status, 8'h60);
        tx_take();
        chk("R5 set", status, 8'hF0);
        bus_read(2'b10);

        dcd_n = 1'b0;
        cyc(); cyc();
        chk("R8 dcd bit", {7'b0, status[5]}, 8'h00);
        chk("R8 irq early", {7'b0, irq_n}, 8'h01);
        cyc();
        chk("R8 irq", {7'b0, irq_n}, 8'h00);

        bus_write(2'b10, 6'h00);
        chk("R11 modem irq released", {7'b0, irq_n}, 8'h01);
        chk("R10 dtr_n", {7'b0, dtr_n}, 8'h01);
        chk("R10 status", status, 8'h50);
        dsr_n = 1'b0;
        repeat (4) cyc();
        chk("R11 dsr tracks", status, 8'h10);
        chk("R11 no irq", {7'b0, irq_n}, 8'h01);

        bus_write(2'b11, 6'h03);
        rx_char(1'b0, 1'b0);
        bus_write(2'b10, 6'h00);
        chk("R11 data irq kept", {7'b0, irq_n}, 8'h00);
        chk("R11 status", status, 8'h98);
        bus_read(2'b10);
        bus_read(2'b00);
        dcd_n = 1'b1; dsr_n = 1'b1;
        repeat (4) cyc();
        chk("R10 idle status", status, 8'h70);

        bus_write(2'b11, 6'h05);
        cts_n = 1'b0;
        repeat (4) cyc();
        chk("R9 cts fall", {7'b0, irq_n}, 8'h01);
        cts_n = 1'b1;
        cyc(); cyc();
        chk("R9 cts early", {7'b0, irq_n}, 8'h01);
        cyc();
        chk("R9 cts rise", {7'b0, irq_n}, 8'h00);
        bus_read(2'b10);

        bus_write(2'b11, 6'h08);
        chk("R13 echo rts", {7'b0, rts_n}, 8'h00);

        bus_write(2'b11, 6'h16);
        rx_char(1'b1, 1'b1);
        tx_take();
        dcd_n = 1'b0;
        repeat (4) cyc();
        chk("R12 masked", {7'b0, irq_n}, 8'h01);
        chk("R12 tx_run", {7'b0, tx_run}, 8'h00);
        dcd_n = 1'b1;
        repeat (4) cyc();
        bus_read(2'b00);

        bus_write(2'b11, 6'h03);
        rs = 2'b10; bus_rd = 1'b1; rx_done = 1'b1; cyc(); idle();
        chk("R7 new event wins", {7'b0, irq_n}, 8'h00);
        bus_read(2'b10);
        bus_read(2'b00);
        rs = 2'b00; bus_wr = 1'b1; tx_empty_evt = 1'b1; cyc(); idle();
        chk("R5 set wins", {7'b0, status[4]}, 8'h01);

        for (int i = 0; i < 3000; i++) begin
            int k;
            k = int'($urandom_range(0, 15));
            case (k)
                0, 1, 2: rx_char(1'($urandom), 1'($urandom));
                3, 4:    tx_take();
                5:       bus_read(2'b00);
                6:       bus_write(2'b00, 6'($urandom));
                7, 8:    bus_read(2'b10);
                9:       bus_write(2'b11, 6'($urandom) | (($urandom % 4 != 0) ? 6'h01 : 6'h00));
                10:      if ($urandom % 3 == 0) bus_write(2'b10, 6'h00); else cyc();
                11: begin
                    case ($urandom % 3)
                        0: dcd_n = ~dcd_n;
                        1: dsr_n = ~dsr_n;
                        default: cts_n = ~cts_n;
                    endcase
                    cyc();
                end
                12: begin rs = 2'b00; bus_rd = 1'b1; rx_done = 1'b1;
                          rx_par_err = 1'($urandom); cyc(); idle(); end
                13: begin rs = 2'b00; bus_wr = 1'b1; tx_empty_evt = 1'b1; cyc(); idle(); end
                14: begin rs = 2'b10; bus_rd = 1'b1; rx_done = 1'b1; cyc(); idle(); end
                default: cyc();
            endcase
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule